// File: doc/BRIEF.md
# Bulk-OUT Packet Limit Tracker for Two DMA Channels

Two DMA channels can carry bulk OUT packets into memory, but only one of them may run such a transfer at a time. This block decides which channel runs. When the software handshake mode is selected, it counts finished packets against a limit that firmware has programmed. When the limit is reached, the block stops the running channel and raises that channel's completion interrupt. Firmware then acknowledges the interrupt with a per-channel clear strobe.

Both channels share one 16-bit packet limit, which is written one byte at a time through two write strobes. On each start request the limit is copied into a down-counter. Each packet-done pulse then decrements that counter. A limit of zero means the transfer has no packet limit, so the channel runs until software halts it. A start request that arrives while a channel is already running is refused and sets a sticky error flag. The block does not move data and does not handle USB transactions.

Top module: `dma_pkt_tracker`

## Requirements
- R1: After reset, `ch_run`, `irq` and `busy_err` are all zero, and the shared limit is zero.
- R2: `lim_wr_lo` writes `lim_wdata` into bits 7:0 of the shared limit and `lim_wr_hi` writes it into bits 15:8. Each byte can be written without changing the other byte.
- R3: When no channel is running, a `start` pulse sets `ch_run[chan]` at the next clock edge. The channel takes the limit as it stood before that edge.
- R4: In software handshake mode (`hs_sw_mode`=1) with a nonzero limit N, the N-th accepted `pkt_done` pulse clears `ch_run` and sets `irq` of the running channel at the same edge. The first N-1 pulses change neither output.
- R5: While `hs_sw_mode`=0, `pkt_done` pulses neither stop the running channel nor raise an interrupt.
- R6: A limit of zero sets no packet limit. The channel keeps running and raises no interrupt, whatever the number of `pkt_done` pulses.
- R7: Channel 0 and channel 1 both take their limit from the same shared register.
- R8: A `start` while a channel is running is ignored, so `ch_run` is unchanged. It also sets `busy_err`, which stays at 1 until reset. At most one bit of `ch_run` is ever set.
- R9: `irq_clr[i]` clears `irq[i]` without affecting the other channel's interrupt. If a completion and a clear for the same channel fall in the same cycle, the completion wins.
- R10: `halt` stops the running channel without raising an interrupt. If `halt` and the final `pkt_done` arrive in the same cycle, `halt` wins and no interrupt is raised.
- R11: A `pkt_done` pulse while no channel is running is ignored and does not consume any of the next transfer's limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_sw_mode | input | 1 | 1 selects software handshake mode, which enables packet counting |
| start | input | 1 | Single-cycle request to start the channel given by `chan` |
| chan | input | 1 | Channel selected by `start` |
| halt | input | 1 | Single-cycle software stop of the running channel |
| pkt_done | input | 1 | Single-cycle pulse for each completed bulk OUT packet |
| lim_wr_lo | input | 1 | Write strobe for the low byte of the limit |
| lim_wr_hi | input | 1 | Write strobe for the high byte of the limit |
| lim_wdata | input | 8 | Byte written by either limit strobe |
| irq_clr | input | 2 | Per-channel interrupt clear strobes |
| ch_run | output | 2 | Run (1) or stop (0) for each channel |
| irq | output | 2 | Per-channel completion interrupt requests |
| busy_err | output | 1 | Sticky flag for a refused start request |

## Verification
The assertions assume that `start`, `halt` and `pkt_done` are single-cycle strobes that firmware and the packet engine issue at most once per cycle each. They also assume that `hs_sw_mode` is held steady across a transfer. The stimulus pulses each strobe for exactly one clock. It changes the mode only while both channels are stopped. It combines strobes in the same cycle only in the tie-break cases that R9 and R10 name. Expected stop cycles come from sweeping the programmed limit, both bytes included, across both channels.

// File: rtl/dma_pkt_pkg.sv
package dma_pkt_pkg;
    localparam int NUM_CH = 2;
    localparam int BYTE_W = 8;
    localparam int NUM_BYTES = 2;
    localparam int LIM_W = BYTE_W * NUM_BYTES;

    typedef struct packed {
        logic [NUM_CH-1:0] run;
        logic              err;
    } trk_state_t;
endpackage

// File: rtl/dma_lim_reg.sv
module dma_lim_reg
    import dma_pkt_pkg::*;
#(
    parameter int LANE_W = BYTE_W,
    parameter int LANES  = NUM_BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        wr_en,
    input  logic [LANE_W-1:0]       wdata,
    output logic [LANES*LANE_W-1:0] lim
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (wr_en[g]) lane_d = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lane_d;
        end

        assign lim[g*LANE_W +: LANE_W] = lane_q;
    end
endmodule

// File: rtl/dma_pkt_down.sv
module dma_pkt_down #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         limited,
    output logic         last
);
    logic [W-1:0] rem_d, rem_q;
    logic         lim_d, lim_q;

    always_comb begin
        rem_d = rem_q;
        lim_d = lim_q;
        if (load) begin
            rem_d = load_val;
            lim_d = (load_val != '0);
        end else if (dec && lim_q && rem_q != '0) begin
            rem_d = rem_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            lim_q <= 1'b0;
        end else begin
            rem_q <= rem_d;
            lim_q <= lim_d;
        end
    end

    assign limited = lim_q;
    assign last    = lim_q && (rem_q == W'(1));
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        logic f_d, f_q;

        always_comb begin
            f_d = f_q;
            if (clr[g]) f_d = 1'b0;
            if (set[g]) f_d = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= f_d;
        end

        assign flag[g] = f_q;
    end
endmodule

// File: rtl/dma_pkt_tracker.sv
module dma_pkt_tracker
    import dma_pkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_sw_mode,
    input  logic              start,
    input  logic              chan,
    input  logic              halt,
    input  logic              pkt_done,
    input  logic              lim_wr_lo,
    input  logic              lim_wr_hi,
    input  logic [BYTE_W-1:0] lim_wdata,
    input  logic [NUM_CH-1:0] irq_clr,
    output logic [NUM_CH-1:0] ch_run,
    output logic [NUM_CH-1:0] irq,
    output logic              busy_err
);
    trk_state_t st_d, st_q;

    logic [LIM_W-1:0]  lim;
    logic              limited, last;
    logic              running, start_ok, count_ev, hit;
    logic [NUM_CH-1:0] irq_set;

    dma_lim_reg #(.LANE_W(BYTE_W), .LANES(NUM_BYTES)) u_lim (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en ({lim_wr_hi, lim_wr_lo}),
        .wdata (lim_wdata),
        .lim   (lim)
    );

    dma_pkt_down #(.W(LIM_W)) u_down (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .load_val (lim),
        .dec      (count_ev),
        .limited  (limited),
        .last     (last)
    );

    dma_irq_flags #(.N(NUM_CH)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .clr   (irq_clr),
        .flag  (irq)
    );

    always_comb begin
        running  = |st_q.run;
        start_ok = start && !running;
        count_ev = pkt_done && running && hs_sw_mode && limited && !halt;
        hit      = count_ev && last;
        irq_set  = hit ? st_q.run : '0;

        st_d = st_q;
        if (start && running) st_d.err = 1'b1;
        if (halt || hit) begin
            st_d.run = '0;
        end else if (start_ok) begin
            st_d.run = '0;
            st_d.run[chan] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch_run   = st_q.run;
    assign busy_err = st_q.err;
endmodule

// File: rtl/dma_pkt_tracker_chk.sv
module dma_pkt_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_sw_mode,
    input logic       start,
    input logic       halt,
    input logic       pkt_done,
    input logic [1:0] irq_clr,
    input logic [1:0] ch_run,
    input logic [1:0] irq,
    input logic       busy_err
);
    p_run_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_run));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err |=> busy_err);

    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_run && start) |=> busy_err);

    p_halt_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (ch_run == 2'b00));

    for (genvar i = 0; i < 2; i++) begin : g_ch
        p_irq_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> $past(pkt_done && ch_run[i] && hs_sw_mode && !halt));

        p_no_hs_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_run[i] && !hs_sw_mode && !halt) |=> ch_run[i]);

        p_halt_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (halt && !irq[i]) |=> !irq[i]);

        p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_clr[i] && !ch_run[i]) |=> !irq[i]);
    end
endmodule

bind dma_pkt_tracker dma_pkt_tracker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_sw_mode (hs_sw_mode),
    .start      (start),
    .halt       (halt),
    .pkt_done   (pkt_done),
    .irq_clr    (irq_clr),
    .ch_run     (ch_run),
    .irq        (irq),
    .busy_err   (busy_err)
);

// File: tb/tb_dma_pkt_tracker.sv
module tb_dma_pkt_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_sw_mode = 1'b1;
    logic       start = 1'b0;
    logic       chan = 1'b0;
    logic       halt = 1'b0;
    logic       pkt_done = 1'b0;
    logic       lim_wr_lo = 1'b0;
    logic       lim_wr_hi = 1'b0;
    logic [7:0] lim_wdata = '0;
    logic [1:0] irq_clr = '0;
    logic [1:0] ch_run, irq;
    logic       busy_err;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dma_pkt_tracker dut (
        .clk(clk), .rst_n(rst_n), .hs_sw_mode(hs_sw_mode), .start(start),
        .chan(chan), .halt(halt), .pkt_done(pkt_done), .lim_wr_lo(lim_wr_lo),
        .lim_wr_hi(lim_wr_hi), .lim_wdata(lim_wdata), .irq_clr(irq_clr),
        .ch_run(ch_run), .irq(irq), .busy_err(busy_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_lim(input logic hi, input logic [7:0] b);
        lim_wdata = b;
        if (hi) lim_wr_hi = 1'b1; else lim_wr_lo = 1'b1;
        cyc();
        lim_wr_hi = 1'b0;
        lim_wr_lo = 1'b0;
    endtask

    task automatic go(input logic c);
        chan = c; start = 1'b1;
        cyc();
        start = 1'b0;
    endtask

    task automatic pkts(input int n);
        for (int k = 0; k < n; k++) begin
            pkt_done = 1'b1;
            cyc();
            pkt_done = 1'b0;
        end
    endtask

    task automatic stop();
        halt = 1'b1;
        cyc();
        halt = 1'b0;
    endtask

    task automatic clr(input logic [1:0] m);
        irq_clr = m;
        cyc();
        irq_clr = '0;
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lims[6];
        lims = '{1, 2, 3, 7, 256, 258};
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1 run", ch_run, 0);
        chk("R1 irq", irq, 0);
        chk("R1 err", busy_err, 0);

        // R11: pulse while idle, then limit 2 must still take two packets
        pkts(1);
        chk("R11 idle pkt", {ch_run, irq}, 0);

        // R2 R3 R4 R7: sweep limits over both channels
        for (int c = 0; c < 2; c++) begin
            for (int j = 0; j < 6; j++) begin
                wr_lim(1'b1, 8'(lims[j] >> 8));
                wr_lim(1'b0, 8'(lims[j]));
                go(c[0]);
                chk("R3 R7 run set", ch_run, 2'b01 << c);
                pkts(lims[j] - 1);
                chk("R4 before last", {ch_run, irq}, {2'b01 << c, 2'b00});
                pkts(1);
                chk("R4 stop", ch_run, 0);
                chk("R4 irq", irq, 2'b01 << c);
                clr(2'b01 << c);
                chk("R9 cleared", irq, 0);
            end
        end

        // R2: rewrite only the low byte of 0x0103 to 0x02, expect 258
        wr_lim(1'b1, 8'h01);
        wr_lim(1'b0, 8'h03);
        wr_lim(1'b0, 8'h02);
        go(1'b0);
        pkts(257);
        chk("R2 byte lane hold", ch_run, 2'b01);
        pkts(1);
        chk("R2 byte lane stop", {ch_run, irq}, {2'b00, 2'b01});
        clr(2'b01);

        // R5: non-handshake mode
        wr_lim(1'b1, 8'h00);
        wr_lim(1'b0, 8'h02);
        hs_sw_mode = 1'b0;
        go(1'b1);
        pkts(6);
        chk("R5 no stop", {ch_run, irq}, {2'b10, 2'b00});
        stop();
        hs_sw_mode = 1'b1;

        // R6: zero limit
        wr_lim(1'b0, 8'h00);
        go(1'b0);
        pkts(40);
        chk("R6 unlimited", {ch_run, irq}, {2'b01, 2'b00});
        stop();
        chk("R10 halt no irq", {ch_run, irq}, 0);

        // R10: halt beats final packet
        wr_lim(1'b0, 8'h01);
        go(1'b1);
        halt = 1'b1; pkt_done = 1'b1;
        cyc();
        halt = 1'b0; pkt_done = 1'b0;
        chk("R10 halt wins", {ch_run, irq}, 0);

        // R9: set beats clear, other channel independent
        go(1'b0);
        pkts(1);
        go(1'b1);
        irq_clr = 2'b10; pkt_done = 1'b1;
        cyc();
        irq_clr = '0; pkt_done = 1'b0;
        chk("R9 set wins", irq, 2'b11);
        clr(2'b01);
        chk("R9 independent", irq, 2'b10);
        clr(2'b10);
        chk("R8 no err yet", busy_err, 0);

        // R8: second start refused
        wr_lim(1'b0, 8'h00);
        go(1'b0);
        go(1'b1);
        chk("R8 ignored", ch_run, 2'b01);
        chk("R8 err", busy_err, 1);
        stop();
        cyc();
        chk("R8 sticky", busy_err, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule